// File: doc/BRIEF.md
# Port-Windowed RAM Disk Controller

This block sits on a Z80-style I/O bus and gives the host access to a memory of up to 2^ADDR_W bytes through five consecutive I/O ports. The host sets a memory address through three byte-wide address ports, then moves bytes one at a time through a data port. After every data-port transfer, only the low address byte advances by one. This lets a block-transfer instruction loop stream a run of up to 256 bytes without rewriting the address.

The advance is deferred. A data access, or a write to the low address port, only sets a pending flag. The low-byte register changes at the next opcode fetch (the falling edge of M1), so the memory address stays fixed during the bus transfer itself. The topmost address bit splits the space into a RAM half and a ROM half. Data writes to the ROM half are dropped. A status port reports readiness and the region of the current address.

Top module: `ramdisk_io_ctrl`

## Requirements
- R1: The block answers only to I/O addresses IO_BASE through IO_BASE+4 (default 90h..94h) during an I/O cycle with M1 high. Accesses to any other port cause no memory strobe and no register change, and read data is 00h.
- R2: Port offsets: +0 is the low address byte, +1 the middle byte, +2 the high byte, +3 the data port and +4 the status port. Reads of the three address ports return the current register values.
- R3: The high register keeps only ADDR_W-16 bits (2 by default). Its upper written bits are dropped and read back as 0.
- R4: mem_addr is {high, middle, low}. A data-port read asserts mem_re and returns the memory byte at mem_addr.
- R5: After each data-port read or write, the low byte increments by one, modulo 256, at the next falling edge of M1. The middle and high bytes never change on an increment, including on the FFh to 00h wrap.
- R6: A write to the low address port takes effect only at the next falling edge of M1. Until then, mem_addr and a low-port read show the old value.
- R7: mem_cs_ram is asserted during a data access when address bit ADDR_W-1 is 0, and mem_cs_rom when it is 1. A data write pulses mem_we for one cycle with mem_wdata, but only in the RAM region. ROM-region writes produce no mem_we, and the address still advances.
- R8: mem_addr does not change while a data-port access is in progress.
- R9: The status port reads bit0 = 1 (ready), bit1 = current address in the ROM region, and all other bits 0. Writes to the status port change nothing.
- R10: The middle and high registers load in the first cycle of the host write.
- R11: Synchronous active-high reset clears all address registers and pending flags.
- R12: Each pending flag is set by its strobe and cleared by the next M1 falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; host bus signals are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| iorq_n | input | 1 | Host I/O request, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| m1_n | input | 1 | Host opcode fetch cycle, active low |
| io_addr | input | 8 | Host I/O port address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data to host |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_ram | output | 1 | RAM region select during data access |
| mem_cs_rom | output | 1 | ROM region select during data access |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write pulse (RAM region only) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data (one-cycle synchronous) |

## Verification
The low address port is swept through all 256 values, and each value is read back after the next fetch. This separates a correct deferred load from a load that is lost or lands early. More than 256 data reads are then streamed from a nonzero middle and high address, and each returned byte is compared with an arithmetic address pattern. This distinguishes a proper 8-bit wrap from a carry into the middle byte or a skipped step. Write bursts are issued in both regions to separate write gating from address advance. Neighbouring ports just outside the window, reads before a fetch, status writes and a mid-run reset each probe one isolated rule.

// File: rtl/ramdisk_pkg.sv
package ramdisk_pkg;
   localparam int NUM_PORTS = 5;
   localparam int BYTE_W    = 8;

   typedef enum logic [2:0] {
      PORT_LO   = 3'd0,
      PORT_MID  = 3'd1,
      PORT_HI   = 3'd2,
      PORT_DATA = 3'd3,
      PORT_STAT = 3'd4
   } port_sel_e;

   localparam int STAT_READY_BIT = 0;
   localparam int STAT_ROM_BIT   = 1;
endpackage

// File: rtl/rd_port_decode.sv
module rd_port_decode
   import ramdisk_pkg::*;
#(
   parameter logic [7:0] IO_BASE = 8'h90
) (
   input  logic       iorq_n,
   input  logic       rd_n,
   input  logic       wr_n,
   input  logic       m1_n,
   input  logic [7:0] io_addr,
   output port_sel_e  sel_o,
   output logic       rd_act_o,
   output logic       wr_act_o
);
   logic [7:0] offset;
   logic       hit;

   always_comb begin
      offset   = io_addr - IO_BASE;
      hit      = ~iorq_n & m1_n & (offset < 8'(NUM_PORTS));
      sel_o    = port_sel_e'(offset[2:0]);
      rd_act_o = hit & ~rd_n;
      wr_act_o = hit & ~wr_n & rd_n;
   end
endmodule

// File: rtl/rd_stretch_latch.sv
module rd_stretch_latch (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (rst)        q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   AST_SET_HOLDS: assert property (@(posedge clk) disable iff (rst)
      set_i |=> q_o);                                   // R12
   AST_FETCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !set_i) |=> !q_o);                      // R12
endmodule

// File: rtl/rd_low_counter.sv
module rd_low_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step_i,
   input  logic         load_sel_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] cnt_o
);
   initial begin
      if (W < 1) $error("rd_low_counter: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst)             cnt_o <= '0;
      else if (step_i) begin
         if (load_sel_i)   cnt_o <= load_val_i;
         else              cnt_o <= cnt_o + W'(1);
      end
   end

   AST_LOW_STEP: assert property (@(posedge clk) disable iff (rst)
      (step_i && !load_sel_i) |=> (cnt_o == $past(cnt_o) + W'(1)));   // R5
   AST_LOW_LOAD: assert property (@(posedge clk) disable iff (rst)
      (step_i && load_sel_i) |=> (cnt_o == $past(load_val_i)));       // R6
   AST_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(cnt_o));                                    // R8
endmodule

// File: rtl/ramdisk_io_ctrl.sv
module ramdisk_io_ctrl
   import ramdisk_pkg::*;
#(
   parameter logic [7:0] IO_BASE = 8'h90,
   parameter int         ADDR_W  = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              m1_n,
   input  logic [7:0]        io_addr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_ram,
   output logic              mem_cs_rom,
   output logic              mem_re,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   localparam int HI_W       = ADDR_W - 2 * BYTE_W;
   localparam int REGION_BIT = ADDR_W - 1;
   localparam int N_LATCH    = 2;
   localparam int LT_LOAD    = 0;
   localparam int LT_DATA    = 1;

   initial begin
      if (ADDR_W < 17 || ADDR_W > 24) $error("ramdisk_io_ctrl: ADDR_W must be 17..24");
      if (IO_BASE > 8'd251)           $error("ramdisk_io_ctrl: port window exceeds 8-bit space");
   end

   port_sel_e          sel;
   logic               rd_act, wr_act, acc_act, acc_q;
   logic               acc_start, wr_start, data_act, data_act_q;
   logic               m1_q, m1_fall;
   logic [N_LATCH-1:0] set_v, pend_v;
   logic [7:0]         lo_q, mid_q, lo_pend;
   logic [HI_W-1:0]    hi_q;
   logic [7:0]         hi_rd, status;
   logic               in_rom;

   rd_port_decode #(.IO_BASE(IO_BASE)) u_dec (
      .iorq_n  (iorq_n),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .m1_n    (m1_n),
      .io_addr (io_addr),
      .sel_o   (sel),
      .rd_act_o(rd_act),
      .wr_act_o(wr_act)
   );

   always_comb begin
      acc_act   = rd_act | wr_act;
      acc_start = acc_act & ~acc_q;
      wr_start  = wr_act & ~acc_q;
      data_act  = acc_act & (sel == PORT_DATA);
      m1_fall   = m1_q & ~m1_n;
      set_v[LT_LOAD] = wr_start & (sel == PORT_LO);
      set_v[LT_DATA] = acc_start & (sel == PORT_DATA);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q      <= 1'b0;
         m1_q       <= 1'b1;
         data_act_q <= 1'b0;
      end else begin
         acc_q      <= acc_act;
         m1_q       <= m1_n;
         data_act_q <= data_act;
      end
   end

   for (genvar g = 0; g < N_LATCH; g++) begin : g_stretch
      rd_stretch_latch u_lat (
         .clk  (clk),
         .rst  (rst),
         .set_i(set_v[g]),
         .clr_i(m1_fall),
         .q_o  (pend_v[g])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_pend <= '0;
         mid_q   <= '0;
         hi_q    <= '0;
      end else begin
         if (set_v[LT_LOAD])                 lo_pend <= io_wdata;
         if (wr_start && sel == PORT_MID)    mid_q   <= io_wdata;
         if (wr_start && sel == PORT_HI)     hi_q    <= io_wdata[HI_W-1:0];
      end
   end

   rd_low_counter #(.W(BYTE_W)) u_lo (
      .clk       (clk),
      .rst       (rst),
      .step_i    (m1_fall & (|pend_v)),
      .load_sel_i(pend_v[LT_LOAD]),
      .load_val_i(lo_pend),
      .cnt_o     (lo_q)
   );

   if (HI_W == BYTE_W) begin : g_hi_full
      assign hi_rd = hi_q;
   end else begin : g_hi_pad
      assign hi_rd = {{(BYTE_W-HI_W){1'b0}}, hi_q};
   end

   always_comb begin
      mem_addr   = {hi_q, mid_q, lo_q};
      in_rom     = mem_addr[REGION_BIT];
      mem_cs_ram = data_act & ~in_rom;
      mem_cs_rom = data_act & in_rom;
      mem_re     = rd_act & (sel == PORT_DATA);
      mem_we     = wr_start & (sel == PORT_DATA) & ~in_rom;
      mem_wdata  = io_wdata;
      status     = '0;
      status[STAT_READY_BIT] = 1'b1;
      status[STAT_ROM_BIT]   = in_rom;
      io_rdata   = '0;
      if (rd_act) begin
         case (sel)
            PORT_LO:   io_rdata = lo_q;
            PORT_MID:  io_rdata = mid_q;
            PORT_HI:   io_rdata = hi_rd;
            PORT_DATA: io_rdata = mem_rdata;
            PORT_STAT: io_rdata = status;
            default:   io_rdata = '0;
         endcase
      end
   end

   AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
      (data_act && data_act_q) |-> $stable(mem_addr));                // R8
   AST_UPPER_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
      (m1_fall && !acc_act) |=> ($stable(mid_q) && $stable(hi_q)));   // R5
   AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (mem_cs_ram && !mem_cs_rom));                        // R7
   AST_SELECT_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0({mem_cs_ram, mem_cs_rom}));                            // R7
endmodule

// File: tb/ramdisk_io_ctrl_test.sv
module ramdisk_io_ctrl_test;
   localparam logic [7:0] BASE = 8'h90;
   localparam int AW = 18;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
   logic [7:0] io_addr = '0, io_wdata = '0, io_rdata;
   logic [AW-1:0] mem_addr;
   logic mem_cs_ram, mem_cs_rom, mem_re, mem_we;
   logic [7:0] mem_wdata, mem_rdata = '0;

   int n_cmp = 0, n_bad = 0;
   int we_cnt = 0, rom_cs_cnt = 0, strobe_cnt = 0;
   logic [AW-1:0] last_wa = '0;
   logic [7:0] last_wd = '0;

   always #5 clk = ~clk;

   ramdisk_io_ctrl #(.IO_BASE(BASE), .ADDR_W(AW)) uut (
      .clk(clk), .rst(rst), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .mem_addr(mem_addr), .mem_cs_ram(mem_cs_ram), .mem_cs_rom(mem_cs_rom),
      .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] pat(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'hA5;
   endfunction

   always @(posedge clk) begin
      if (mem_re) mem_rdata <= pat(mem_addr);
      if (mem_we) begin
         we_cnt  <= we_cnt + 1;
         last_wa <= mem_addr;
         last_wd <= mem_wdata;
      end
      if (mem_cs_rom) rom_cs_cnt <= rom_cs_cnt + 1;
      if (mem_re || mem_we || mem_cs_ram || mem_cs_rom) strobe_cnt <= strobe_cnt + 1;
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic io_op(input logic [7:0] port, input bit is_wr, input logic [7:0] d,
                        output logic [7:0] q);
      @(negedge clk);
      io_addr = port; io_wdata = d; iorq_n = 1'b0;
      if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
      repeat (3) @(negedge clk);
      q = io_rdata;
      iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic fetch();
      @(negedge clk) m1_n = 1'b0;
      repeat (2) @(negedge clk);
      m1_n = 1'b1;
   endtask

   task automatic wr_port(input logic [7:0] port, input logic [7:0] d);
      logic [7:0] dummy;
      io_op(port, 1'b1, d, dummy);
      fetch();
   endtask

   task automatic rd_port(input logic [7:0] port, output logic [7:0] q);
      io_op(port, 1'b0, 8'h00, q);
      fetch();
   endtask

   task automatic set_addr(input logic [7:0] h, input logic [7:0] m, input logic [7:0] l);
      wr_port(BASE + 8'd2, h);
      wr_port(BASE + 8'd1, m);
      wr_port(BASE + 8'd0, l);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] q;
      int w0, s0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R11 reset state
      rd_port(BASE, q);            check("R11 low after reset", q, 8'h00);
      rd_port(BASE + 8'd1, q);     check("R11 mid after reset", q, 8'h00);
      rd_port(BASE + 8'd2, q);     check("R11 high after reset", q, 8'h00);
      rd_port(BASE + 8'd4, q);     check("R9 status ready in RAM", q, 8'h01);

      // R10 R3 middle/high load and high truncation
      wr_port(BASE + 8'd1, 8'h34);
      rd_port(BASE + 8'd1, q);     check("R10 mid readback", q, 8'h34);
      wr_port(BASE + 8'd2, 8'hFD);
      rd_port(BASE + 8'd2, q);     check("R3 high upper bits dropped", q, 8'h01);
      wr_port(BASE + 8'd2, 8'hFF);
      rd_port(BASE + 8'd4, q);     check("R9 status ROM flag", q, 8'h03);

      // R6 deferred low load
      wr_port(BASE, 8'h22);
      io_op(BASE, 1'b1, 8'h10, q);
      check("R6 mem_addr low before fetch", {24'b0, mem_addr[7:0]}, 32'h22);
      io_op(BASE, 1'b0, 8'h00, q);
      check("R6 low port before fetch", q, 8'h22);
      fetch();
      rd_port(BASE, q);            check("R6 low port after fetch", q, 8'h10);

      // R2 R6 sweep of all low values
      for (int v = 0; v < 256; v++) begin
         wr_port(BASE, 8'(v));
         rd_port(BASE, q);
         check("R2 low sweep", q, 32'(v));
      end

      // R4 R5 streaming reads with wrap, no carry
      set_addr(8'h01, 8'hC3, 8'hF0);
      for (int i = 0; i < 270; i++) begin
         logic [AW-1:0] a;
         a = {2'b01, 8'hC3, 8'(8'hF0 + i)};
         rd_port(BASE + 8'd3, q);
         check("R4 data read pattern", q, 32'(pat(a)));
      end
      rd_port(BASE, q);            check("R5 low after stream", q, 32'(8'(8'hF0 + 8'd14)));
      rd_port(BASE + 8'd1, q);     check("R5 mid no carry", q, 8'hC3);
      rd_port(BASE + 8'd2, q);     check("R5 high no carry", q, 8'h01);

      // R7 RAM writes
      set_addr(8'h00, 8'h20, 8'h7E);
      w0 = we_cnt;
      wr_port(BASE + 8'd3, 8'hAA);
      wr_port(BASE + 8'd3, 8'hBB);
      wr_port(BASE + 8'd3, 8'hCC);
      check("R7 RAM write count", 32'(we_cnt - w0), 32'd3);
      check("R7 last write address", 32'(last_wa), 32'h02080);
      check("R7 last write data", last_wd, 8'hCC);
      rd_port(BASE, q);            check("R5 low after writes", q, 8'h81);

      // R7 ROM writes blocked, reads select ROM
      set_addr(8'h02, 8'h00, 8'hFE);
      w0 = we_cnt;
      s0 = rom_cs_cnt;
      wr_port(BASE + 8'd3, 8'h55);
      wr_port(BASE + 8'd3, 8'h66);
      check("R7 ROM write ignored", 32'(we_cnt - w0), 32'd0);
      check("R7 ROM select asserted", 32'(rom_cs_cnt > s0), 32'd1);
      rd_port(BASE, q);            check("R7 ROM write still advances", q, 8'h00);
      rd_port(BASE + 8'd3, q);     check("R4 ROM read", q, 32'(pat(18'h20000)));

      // R9 status write has no effect
      wr_port(BASE + 8'd4, 8'h00);
      rd_port(BASE + 8'd4, q);     check("R9 status after write", q, 8'h03);
      rd_port(BASE, q);            check("R9 low after status write", q, 8'h01);

      // R1 ports outside window
      s0 = strobe_cnt;
      wr_port(BASE - 8'd1, 8'h77);
      wr_port(BASE + 8'd5, 8'h77);
      rd_port(BASE + 8'd5, q);     check("R1 outside read data", q, 8'h00);
      rd_port(BASE - 8'd1, q);     check("R1 below read data", q, 8'h00);
      check("R1 no memory strobes", 32'(strobe_cnt - s0), 32'd0);
      rd_port(BASE, q);            check("R1 low untouched", q, 8'h01);
      rd_port(BASE + 8'd1, q);     check("R1 mid untouched", q, 8'h00);

      // R11 R12 reset mid-run clears registers and pending flag
      set_addr(8'h03, 8'h99, 8'h44);
      io_op(BASE + 8'd3, 1'b0, 8'h00, q);
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      fetch();
      rd_port(BASE, q);            check("R12 pending cleared by reset", q, 8'h00);
      rd_port(BASE + 8'd1, q);     check("R11 mid cleared", q, 8'h00);
      rd_port(BASE + 8'd2, q);     check("R11 high cleared", q, 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule